// File: doc/BRIEF.md
# Region-Attribute Cache Control Unit

This unit sits next to a small cache and turns every CPU memory access into three policy decisions: whether the access may be cached, whether a write may update a cached line, and whether a write must flush the whole cache. The decisions come from three 32-bit region bitmaps. Each bitmap splits a 64 MB virtual space into 32 regions of 2 MB. A small control register enables the cache, marks user and privileged code as sharing one address mapping, and selects a trace-friendly monitor mode.

Software programs the unit through a coprocessor-style register port: a request strobe, a write flag, a 4-bit register number and 32-bit data. Only privileged requests are accepted. The unit also produces a one-cycle flush strobe. The strobe fires on an explicit flush command or on a write to a region marked as disruptive. The cache arrays, tags and bus interface belong to the surrounding logic.

Top module: `region_cache_ctrl`

## Requirements
- R1: After reset, `cache_en_o`, `shared_map_o`, `monitor_o`, `flush_o` and `cfg_err_o` are low, and a read of register 2 returns 0.
- R2: A privileged write to register 2 stores data bits 0 (cache enable), 1 (shared mapping) and 2 (monitor mode). These drive `cache_en_o`, `shared_map_o` and `monitor_o`. A read of register 2 returns them in bits 2:0, with all other bits 0.
- R3: A read of register 0 returns the identification constant `ID_VALUE` (default 32'h5243_0001). Writes to register 0 leave it unchanged.
- R4: Any privileged write to register 1, whatever its data, makes `flush_o` high for exactly one cycle, in the cycle after the request.
- R5: Bit n of registers 3, 4 and 5 governs virtual addresses n×2 MB to n×2 MB+2 MB−1. Address bits 25:21 give n.
- R6: `cacheable_o` is high only for a valid access while the cache is enabled and the region's bit in register 3 is 1.
- R7: `upd_ok_o` is high only for a valid write while the cache is enabled and the region's bit in register 4 is 1. A read, or a write to a region whose bit is 0, gives 0.
- R8: `disrupt_o` is high for a valid write to a region whose bit in register 5 is 1, whether or not the cache is enabled. Such a write makes `flush_o` high in the next cycle.
- R9: An explicit flush and a disruptive write in the same cycle give a single `flush_o` pulse one cycle wide.
- R10: A request while `cfg_priv_i` is low makes `cfg_err_o` high in the next cycle. It changes no register and leaves `cfg_rdata_o` unchanged.
- R11: Writes to register numbers 0, 1 and 6 to 15 change no stored value. Reads of registers 1 and 6 to 15 return 0.
- R12: `cfg_rdata_o` is registered. It shows read data in the cycle after a privileged read request and holds it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Register access request |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_sel_i | input | 4 | Register number |
| cfg_wdata_i | input | 32 | Write data |
| cfg_priv_i | input | 1 | Requester is privileged |
| cfg_rdata_o | output | 32 | Registered read data |
| cfg_err_o | output | 1 | Unprivileged access pulse |
| acc_valid_i | input | 1 | CPU access valid |
| acc_write_i | input | 1 | CPU access is a write |
| acc_addr_i | input | 26 | CPU virtual address |
| cacheable_o | output | 1 | Access may be cached |
| upd_ok_o | output | 1 | Write may update a cached line |
| disrupt_o | output | 1 | Write requires full flush |
| flush_o | output | 1 | One-cycle full-cache flush strobe |
| cache_en_o | output | 1 | Cache enable |
| shared_map_o | output | 1 | User and privileged share mapping |
| monitor_o | output | 1 | Monitor mode |

## Verification
The properties assume that every input is a known value at each clock edge. They also assume that the access inputs are meaningful only when `acc_valid_i` is high. The stimulus changes inputs only on the falling edge and returns every strobe to low once its cycle is done. The region bitmaps are written before the cache is enabled, so the properties never depend on the bitmaps' state before programming.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef struct packed {
    logic monitor;
    logic shared_map;
    logic cache_en;
  } ctrl_t;

  typedef enum logic [3:0] {
    REG_ID        = 4'd0,
    REG_FLUSH     = 4'd1,
    REG_CTRL      = 4'd2,
    REG_CACHEABLE = 4'd3,
    REG_UPDATE    = 4'd4,
    REG_DISRUPT   = 4'd5
  } reg_sel_e;

  localparam int unsigned NUM_MAPS = 3;
  localparam int unsigned MAP_BASE = 3;  // register number of first bitmap
  localparam int unsigned MAP_CACHE = 0;
  localparam int unsigned MAP_UPD   = 1;
  localparam int unsigned MAP_DISR  = 2;
endpackage

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_REGION = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5243_0001
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [3:0]                          sel_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  input  logic                                priv_i,
  output ctrl_t                               ctrl_o,
  output logic [NUM_MAPS-1:0][N_REGION-1:0]   map_o,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic                                err_o,
  output logic                                flush_req_o
);
  logic              wr_ok, rd_ok;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              err_q;

  assign wr_ok = req_i & priv_i & we_i;
  assign rd_ok = req_i & priv_i & ~we_i;
  assign flush_req_o = wr_ok & (sel_i == REG_FLUSH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ok && sel_i == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i[2:0]);
  end

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_o[g] <= '0;
      else if (wr_ok && sel_i == 4'(MAP_BASE + g)) map_o[g] <= wdata_i[N_REGION-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel_i)
      REG_ID:        rd_mux = ID_VALUE;
      REG_CTRL:      rd_mux[2:0] = ctrl_q;
      REG_CACHEABLE: rd_mux[N_REGION-1:0] = map_o[MAP_CACHE];
      REG_UPDATE:    rd_mux[N_REGION-1:0] = map_o[MAP_UPD];
      REG_DISRUPT:   rd_mux[N_REGION-1:0] = map_o[MAP_DISR];
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= req_i & ~priv_i;
      if (rd_ok) rdata_q <= rd_mux;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rcc_region_lookup.sv
module rcc_region_lookup
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned REGION_LSB = 21,
  parameter int unsigned N_REGION   = 32
) (
  input  logic                              valid_i,
  input  logic                              write_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              cache_en_i,
  input  logic [NUM_MAPS-1:0][N_REGION-1:0] map_i,
  output logic                              cacheable_o,
  output logic                              upd_ok_o,
  output logic                              disrupt_o
);
  localparam int unsigned IDX_W = ADDR_W - REGION_LSB;

  logic [IDX_W-1:0] idx;
  logic [NUM_MAPS-1:0] hit;

  assign idx = addr_i[ADDR_W-1:REGION_LSB];

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_hit
    assign hit[g] = map_i[g][idx];
  end

  assign cacheable_o = valid_i & cache_en_i & hit[MAP_CACHE];
  assign upd_ok_o    = valid_i & write_i & cache_en_i & hit[MAP_UPD];
  assign disrupt_o   = valid_i & write_i & hit[MAP_DISR];
endmodule

// File: rtl/region_cache_ctrl.sv
module region_cache_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 26,
  parameter int unsigned REGION_LSB = 21,
  parameter int unsigned DATA_W     = 32,
  parameter logic [31:0] ID_VALUE   = 32'h5243_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              cfg_priv_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              cfg_err_o,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              cacheable_o,
  output logic              upd_ok_o,
  output logic              disrupt_o,
  output logic              flush_o,
  output logic              cache_en_o,
  output logic              shared_map_o,
  output logic              monitor_o
);
  localparam int unsigned N_REGION = 2 ** (ADDR_W - REGION_LSB);

  ctrl_t                             ctrl;
  logic [NUM_MAPS-1:0][N_REGION-1:0] maps;
  logic                              flush_req, flush_q;

  rcc_regs #(
    .DATA_W  (DATA_W),
    .N_REGION(N_REGION),
    .ID_VALUE(DATA_W'(ID_VALUE))
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cfg_req_i),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .priv_i     (cfg_priv_i),
    .ctrl_o     (ctrl),
    .map_o      (maps),
    .rdata_o    (cfg_rdata_o),
    .err_o      (cfg_err_o),
    .flush_req_o(flush_req)
  );

  rcc_region_lookup #(
    .ADDR_W    (ADDR_W),
    .REGION_LSB(REGION_LSB),
    .N_REGION  (N_REGION)
  ) i_lookup (
    .valid_i    (acc_valid_i),
    .write_i    (acc_write_i),
    .addr_i     (acc_addr_i),
    .cache_en_i (ctrl.cache_en),
    .map_i      (maps),
    .cacheable_o(cacheable_o),
    .upd_ok_o   (upd_ok_o),
    .disrupt_o  (disrupt_o)
  );

  // merged strobe: simultaneous sources give one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= flush_req | disrupt_o;
  end

  assign flush_o      = flush_q;
  assign cache_en_o   = ctrl.cache_en;
  assign shared_map_o = ctrl.shared_map;
  assign monitor_o    = ctrl.monitor;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h5243_0001
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_i,
  input logic              cfg_we_i,
  input logic [3:0]        cfg_sel_i,
  input logic              cfg_priv_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              cfg_err_o,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic              cacheable_o,
  input logic              upd_ok_o,
  input logic              disrupt_o,
  input logic              flush_o,
  input logic              cache_en_o,
  input logic              shared_map_o,
  input logic              monitor_o
);
  logic unpriv, flush_cmd, id_rd;
  assign unpriv    = cfg_req_i & ~cfg_priv_i;
  assign flush_cmd = cfg_req_i & cfg_priv_i & cfg_we_i & (cfg_sel_i == 4'd1);
  assign id_rd     = cfg_req_i & cfg_priv_i & ~cfg_we_i & (cfg_sel_i == 4'd0);

  assert_unpriv_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unpriv |=> cfg_err_o && $stable(cache_en_o) && $stable(shared_map_o)
               && $stable(monitor_o) && $stable(cfg_rdata_o));

  assert_flush_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_cmd |=> flush_o);

  assert_no_spurious_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_cmd && !disrupt_o) |=> !flush_o);

  assert_disrupt_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disrupt_o |=> flush_o);

  assert_disabled_uncached_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cache_en_o |-> !cacheable_o);

  assert_read_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && acc_write_i) |-> !upd_ok_o && !disrupt_o);

  assert_id_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_rd |=> cfg_rdata_o == DATA_W'(ID_VALUE));
endmodule

bind region_cache_ctrl rcc_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ID_VALUE(ID_VALUE)
) i_rcc_checker (.*);

// File: tb/test_region_cache_ctrl.sv
`timescale 1ns/1ps
module test_region_cache_ctrl;
  localparam logic [31:0] ID = 32'h5243_0001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_req_i = 0, cfg_we_i = 0, cfg_priv_i = 0;
  logic [3:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        cfg_err_o;
  logic        acc_valid_i = 0, acc_write_i = 0;
  logic [25:0] acc_addr_i = '0;
  logic        cacheable_o, upd_ok_o, disrupt_o, flush_o;
  logic        cache_en_o, shared_map_o, monitor_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  region_cache_ctrl i_region_cache_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic we, input logic [3:0] sel, input logic [31:0] d,
                     input logic priv);
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = d; cfg_priv_i = priv;
    @(posedge clk_i); #1;
    cfg_req_i = 0; cfg_we_i = 0; cfg_priv_i = 0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [31:0] v);
    cfg(1'b0, sel, '0, 1'b1);
    v = cfg_rdata_o;
  endtask

  task automatic acc(input logic wr, input logic [25:0] a);
    @(negedge clk_i);
    acc_valid_i = 1; acc_write_i = wr; acc_addr_i = a;
    #1;
  endtask

  task automatic acc_idle();
    @(negedge clk_i);
    acc_valid_i = 0; acc_write_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cache_en", 32'(cache_en_o), 0);
    check("R1 flush", 32'(flush_o), 0);
    check("R1 err", 32'(cfg_err_o), 0);
    rd(4'd2, v); check("R1 ctrl read", v, 0);
  endtask

  task automatic t_id();
    logic [31:0] v;
    rd(4'd0, v); check("R3 id", v, ID);
    cfg(1'b1, 4'd0, 32'h1234_5678, 1'b1);
    rd(4'd0, v); check("R3 id after write", v, ID);
    cfg(1'b1, 4'd7, 32'hFFFF_FFFF, 1'b1);
    rd(4'd7, v); check("R11 unused reg", v, 0);
    rd(4'd1, v); check("R11 flush reg read", v, 0);
  endtask

  task automatic t_maps();
    logic [31:0] v;
    cfg(1'b1, 4'd3, 32'h8000_0001, 1'b1);
    cfg(1'b1, 4'd4, 32'h0000_0002, 1'b1);
    cfg(1'b1, 4'd5, 32'h0000_0004, 1'b1);
    rd(4'd3, v); check("R5 cacheable map", v, 32'h8000_0001);
    acc(1'b0, 26'h000_0000);
    check("R6 disabled not cacheable", 32'(cacheable_o), 0);
    acc_idle();
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    cfg(1'b1, 4'd2, 32'hFFFF_FFFD, 1'b1);
    check("R2 enable", 32'(cache_en_o), 1);
    check("R2 shared", 32'(shared_map_o), 0);
    check("R2 monitor", 32'(monitor_o), 1);
    rd(4'd2, v); check("R2 ctrl read", v, 32'h5);
    cfg(1'b1, 4'd2, 32'h3, 1'b1);
    rd(4'd2, v); check("R2 ctrl read2", v, 32'h3);
    // R12: data held while no new read
    @(posedge clk_i); #1; check("R12 rdata held", cfg_rdata_o, 32'h3);
  endtask

  task automatic t_lookup();
    acc(1'b0, 26'h000_0000); check("R6 region0 cacheable", 32'(cacheable_o), 1);
    acc(1'b0, 26'h020_0000); check("R5 region1 not cacheable", 32'(cacheable_o), 0);
    acc(1'b0, 26'h3FF_FFFF); check("R5 region31 cacheable", 32'(cacheable_o), 1);
    acc(1'b0, 26'h01F_FFFF); check("R5 region0 top", 32'(cacheable_o), 1);
    acc(1'b1, 26'h020_0010); check("R7 update region1", 32'(upd_ok_o), 1);
    acc(1'b0, 26'h020_0010); check("R7 read no update", 32'(upd_ok_o), 0);
    acc(1'b1, 26'h000_0010); check("R7 region0 no update", 32'(upd_ok_o), 0);
    acc_idle();
  endtask

  task automatic t_flush();
    acc(1'b1, 26'h040_0000);
    check("R8 disrupt", 32'(disrupt_o), 1);
    @(posedge clk_i); #1;
    check("R8 flush pulse", 32'(flush_o), 1);
    acc_valid_i = 0; acc_write_i = 0;
    @(posedge clk_i); #1;
    check("R8 flush ends", 32'(flush_o), 0);
    acc(1'b0, 26'h040_0000); check("R8 read no disrupt", 32'(disrupt_o), 0);
    acc_idle();
    cfg(1'b1, 4'd1, 32'h0, 1'b1);
    check("R4 flush cmd", 32'(flush_o), 1);
    @(posedge clk_i); #1; check("R4 one cycle", 32'(flush_o), 0);
    // R9 both sources together
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 1; cfg_sel_i = 4'd1; cfg_priv_i = 1;
    acc_valid_i = 1; acc_write_i = 1; acc_addr_i = 26'h040_0004;
    @(posedge clk_i); #1;
    cfg_req_i = 0; cfg_we_i = 0; cfg_priv_i = 0; acc_valid_i = 0; acc_write_i = 0;
    check("R9 merged pulse", 32'(flush_o), 1);
    @(posedge clk_i); #1; check("R9 single pulse", 32'(flush_o), 0);
  endtask

  task automatic t_priv();
    logic [31:0] v;
    cfg(1'b1, 4'd2, 32'h0, 1'b0);
    check("R10 err on write", 32'(cfg_err_o), 1);
    check("R10 ctrl kept", 32'(cache_en_o), 1);
    cfg(1'b0, 4'd0, 32'h0, 1'b0);
    check("R10 rdata unchanged", cfg_rdata_o, 32'h3);
    cfg(1'b1, 4'd1, 32'h0, 1'b0);
    check("R10 no flush", 32'(flush_o), 0);
    rd(4'd2, v); check("R10 ctrl readback", v, 32'h3);
    check("R10 err clears", 32'(cfg_err_o), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_id();
    t_maps();
    t_ctrl();
    t_lookup();
    t_flush();
    t_priv();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule